// File: doc/BRIEF.md
# Address and Stack Fault Detector

This block watches the memory-facing activity of a processor core and flags illegal operations as they happen. Four kinds of activity are checked: data-space accesses (byte or word, with an optional dual-operand MAC mode that selects the X or Y half of data memory), data reads that target program memory, instruction fetches, and writes to the stack pointer. Each illegal condition sets its own bit in a cause vector. The bits are grouped into two trap requests: one for address faults and one for stack faults.

The implemented data memory runs from address 0 up to a parameterized last address. A parameterized split point divides it into an X half below the split and a Y half from the split upward. Program memory is implemented from address 0 up to, but not including, a parameterized end address. The lowest program addresses hold the vector table, and instructions may not be fetched from there. Stack pointer writes are checked against a limit register that software supplies and against a fixed floor. The cause vector and both trap requests are registered, so they appear one clock after the offending input. They hold for that single cycle and are then replaced by the next cycle's result. Trap priority and the memories themselves are outside this block.

Top module: `addr_stack_fault`

## Requirements
- R1: A valid data access with the word flag set and address bit 0 set raises cause bit 0 (misaligned).
- R2: A valid data access to an address above the last implemented data address (default 0x0FFF) raises cause bit 1.
- R3: A valid program-space data read at or above the program end address (default 0x008000) raises cause bit 2.
- R4: A valid instruction fetch from the vector region 0x000000 to 0x00007F raises cause bit 3. An address of 0x000080 does not.
- R5: A valid instruction fetch at or above the program end address raises cause bit 4.
- R6: In MAC mode, an X access (Y select low) at or above the split point (default 0x0C00) and within implemented memory raises cause bit 5, and so does a Y access below the split point. Outside MAC mode the split is ignored.
- R7: A stack pointer write with a value strictly greater than the limit input raises cause bit 6. A value equal to the limit does not.
- R8: A stack pointer write with a value below 0x0800 raises cause bit 7. A value of exactly 0x0800 does not.
- R9: The address trap output is the OR of cause bits 0 to 5, and the stack trap output is the OR of bits 6 and 7. Faults raised in the same cycle are all reported together.
- R10: Outputs appear exactly one clock after the inputs that cause them and last only one cycle. Reset clears them at once.
- R11: When a strobe is low, the address or data value that goes with it has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dacc_valid_i | input | 1 | Data access strobe |
| dacc_addr_i | input | DAW | Data byte address |
| dacc_word_i | input | 1 | 1 = word access, 0 = byte access |
| mac_i | input | 1 | Dual-space MAC operand access |
| mac_y_i | input | 1 | MAC space select: 0 = X, 1 = Y |
| pdat_valid_i | input | 1 | Program-space data read strobe |
| pdat_addr_i | input | PAW | Program-space data read address |
| fetch_valid_i | input | 1 | Instruction fetch strobe |
| fetch_addr_i | input | PAW | Instruction fetch address |
| sp_we_i | input | 1 | Stack pointer write strobe |
| sp_wdata_i | input | DAW | New stack pointer value |
| splim_i | input | DAW | Stack limit register value |
| addr_trap_o | output | 1 | Address error trap request |
| stack_trap_o | output | 1 | Stack error trap request |
| cause_o | output | 8 | Registered fault cause bits |

## Verification
The hardest case to reach is several detectors firing in one cycle, across both trap groups. One example is an odd-address word access that falls outside data memory, combined with a stack write above the limit. The driver sets every strobe in the same cycle and expects the merged cause vector. The exact edges are exercised on both sides: the last vector address, the split point in each MAC space, the limit value itself, and the stack floor. Idle strobes carrying faulty addresses check that disabled inputs have no effect.

// File: rtl/asf_pkg.sv
package asf_pkg;
  localparam int CAUSE_W = 8;
  typedef logic [CAUSE_W-1:0] cause_t;

  localparam int C_MISALIGN   = 0;
  localparam int C_DUNIMPL    = 1;
  localparam int C_PDUNIMPL   = 2;
  localparam int C_FVECTOR    = 3;
  localparam int C_FUNIMPL    = 4;
  localparam int C_XYCROSS    = 5;
  localparam int C_SP_OVER    = 6;
  localparam int C_SP_UNDER   = 7;

  localparam cause_t ADDR_MASK  = cause_t'(8'h3F);
  localparam cause_t STACK_MASK = cause_t'(8'hC0);
endpackage

// File: rtl/asf_data_chk.sv
module asf_data_chk #(
  parameter int unsigned     DAW       = 16,
  parameter logic [DAW-1:0]  DMEM_LAST = 16'h0FFF,
  parameter logic [DAW-1:0]  XY_SPLIT  = 16'h0C00
) (
  input  logic           valid_i,
  input  logic [DAW-1:0] addr_i,
  input  logic           word_i,
  input  logic           mac_i,
  input  logic           mac_y_i,
  output logic           misalign_o,
  output logic           unimpl_o,
  output logic           cross_o
);
  logic in_x, in_y;

  always_comb begin
    in_x       = addr_i < XY_SPLIT;
    in_y       = (addr_i >= XY_SPLIT) && (addr_i <= DMEM_LAST);
    misalign_o = valid_i && word_i && addr_i[0];
    unimpl_o   = valid_i && (addr_i > DMEM_LAST);
    // each MAC space treats the other half as absent
    cross_o    = valid_i && mac_i && (mac_y_i ? in_x : in_y);
  end
endmodule

// File: rtl/asf_prog_chk.sv
module asf_prog_chk #(
  parameter int unsigned     PAW      = 24,
  parameter logic [PAW-1:0]  PMEM_END = 24'h008000,
  parameter logic [PAW-1:0]  VEC_LAST = 24'h00007F
) (
  input  logic           fetch_valid_i,
  input  logic [PAW-1:0] fetch_addr_i,
  input  logic           pdat_valid_i,
  input  logic [PAW-1:0] pdat_addr_i,
  output logic           vec_o,
  output logic           fetch_unimpl_o,
  output logic           pdat_unimpl_o
);
  always_comb begin
    vec_o          = fetch_valid_i && (fetch_addr_i <= VEC_LAST);
    fetch_unimpl_o = fetch_valid_i && (fetch_addr_i >= PMEM_END);
    pdat_unimpl_o  = pdat_valid_i && (pdat_addr_i >= PMEM_END);
  end
endmodule

// File: rtl/asf_stack_chk.sv
module asf_stack_chk #(
  parameter int unsigned     DAW      = 16,
  parameter logic [DAW-1:0]  SP_FLOOR = 16'h0800
) (
  input  logic           we_i,
  input  logic [DAW-1:0] wdata_i,
  input  logic [DAW-1:0] lim_i,
  output logic           over_o,
  output logic           under_o
);
  always_comb begin
    over_o  = we_i && (wdata_i > lim_i);
    under_o = we_i && (wdata_i < SP_FLOOR);
  end
endmodule

// File: rtl/addr_stack_fault.sv
module addr_stack_fault
  import asf_pkg::*;
#(
  parameter int unsigned     DAW       = 16,
  parameter int unsigned     PAW       = 24,
  parameter logic [DAW-1:0]  DMEM_LAST = 16'h0FFF,
  parameter logic [DAW-1:0]  XY_SPLIT  = 16'h0C00,
  parameter logic [PAW-1:0]  PMEM_END  = 24'h008000,
  parameter logic [PAW-1:0]  VEC_LAST  = 24'h00007F,
  parameter logic [DAW-1:0]  SP_FLOOR  = 16'h0800
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           dacc_valid_i,
  input  logic [DAW-1:0] dacc_addr_i,
  input  logic           dacc_word_i,
  input  logic           mac_i,
  input  logic           mac_y_i,
  input  logic           pdat_valid_i,
  input  logic [PAW-1:0] pdat_addr_i,
  input  logic           fetch_valid_i,
  input  logic [PAW-1:0] fetch_addr_i,
  input  logic           sp_we_i,
  input  logic [DAW-1:0] sp_wdata_i,
  input  logic [DAW-1:0] splim_i,
  output logic           addr_trap_o,
  output logic           stack_trap_o,
  output logic [7:0]     cause_o
);
  cause_t cause_d, cause_q;

  logic d_mis, d_unimpl, d_cross;
  logic f_vec, f_unimpl, p_unimpl;
  logic s_over, s_under;

  asf_data_chk #(.DAW(DAW), .DMEM_LAST(DMEM_LAST), .XY_SPLIT(XY_SPLIT)) u_data (
    .valid_i   (dacc_valid_i),
    .addr_i    (dacc_addr_i),
    .word_i    (dacc_word_i),
    .mac_i     (mac_i),
    .mac_y_i   (mac_y_i),
    .misalign_o(d_mis),
    .unimpl_o  (d_unimpl),
    .cross_o   (d_cross)
  );

  asf_prog_chk #(.PAW(PAW), .PMEM_END(PMEM_END), .VEC_LAST(VEC_LAST)) u_prog (
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .pdat_valid_i  (pdat_valid_i),
    .pdat_addr_i   (pdat_addr_i),
    .vec_o         (f_vec),
    .fetch_unimpl_o(f_unimpl),
    .pdat_unimpl_o (p_unimpl)
  );

  asf_stack_chk #(.DAW(DAW), .SP_FLOOR(SP_FLOOR)) u_stack (
    .we_i   (sp_we_i),
    .wdata_i(sp_wdata_i),
    .lim_i  (splim_i),
    .over_o (s_over),
    .under_o(s_under)
  );

  always_comb begin
    cause_d             = '0;
    cause_d[C_MISALIGN] = d_mis;
    cause_d[C_DUNIMPL]  = d_unimpl;
    cause_d[C_PDUNIMPL] = p_unimpl;
    cause_d[C_FVECTOR]  = f_vec;
    cause_d[C_FUNIMPL]  = f_unimpl;
    cause_d[C_XYCROSS]  = d_cross;
    cause_d[C_SP_OVER]  = s_over;
    cause_d[C_SP_UNDER] = s_under;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_d;
  end

  assign cause_o      = cause_q;
  assign addr_trap_o  = |(cause_q & ADDR_MASK);
  assign stack_trap_o = |(cause_q & STACK_MASK);
endmodule

// File: rtl/asf_checker.sv
module asf_checker #(
  parameter int unsigned     DAW       = 16,
  parameter int unsigned     PAW       = 24,
  parameter logic [DAW-1:0]  DMEM_LAST = 16'h0FFF,
  parameter logic [DAW-1:0]  XY_SPLIT  = 16'h0C00,
  parameter logic [PAW-1:0]  PMEM_END  = 24'h008000,
  parameter logic [PAW-1:0]  VEC_LAST  = 24'h00007F,
  parameter logic [DAW-1:0]  SP_FLOOR  = 16'h0800
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           dacc_valid_i,
  input logic [DAW-1:0] dacc_addr_i,
  input logic           dacc_word_i,
  input logic           mac_i,
  input logic           mac_y_i,
  input logic           pdat_valid_i,
  input logic [PAW-1:0] pdat_addr_i,
  input logic           fetch_valid_i,
  input logic [PAW-1:0] fetch_addr_i,
  input logic           sp_we_i,
  input logic [DAW-1:0] sp_wdata_i,
  input logic [DAW-1:0] splim_i,
  input logic           addr_trap_o,
  input logic           stack_trap_o,
  input logic [7:0]     cause_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r1_misalign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(dacc_valid_i && dacc_word_i && dacc_addr_i[0]) |-> addr_trap_o && cause_o[0]);

  a_r2_data_unimpl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(dacc_valid_i && (dacc_addr_i > DMEM_LAST)) |-> addr_trap_o && cause_o[1]);

  a_r3_pdat_unimpl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(pdat_valid_i && (pdat_addr_i >= PMEM_END)) |-> addr_trap_o && cause_o[2]);

  a_r4_vector_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(fetch_valid_i && (fetch_addr_i <= VEC_LAST)) |-> addr_trap_o && cause_o[3]);

  a_r5_fetch_unimpl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(fetch_valid_i && (fetch_addr_i >= PMEM_END)) |-> addr_trap_o && cause_o[4]);

  a_r6_y_in_x: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(dacc_valid_i && mac_i && mac_y_i && (dacc_addr_i < XY_SPLIT)) |-> cause_o[5]);

  a_r7_sp_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(sp_we_i && (sp_wdata_i > splim_i)) |-> stack_trap_o && cause_o[6]);

  a_r8_sp_under: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(sp_we_i && (sp_wdata_i < SP_FLOOR)) |-> stack_trap_o && cause_o[7]);

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!dacc_valid_i && !pdat_valid_i && !fetch_valid_i && !sp_we_i)
      |-> cause_o == 8'h00 && !addr_trap_o && !stack_trap_o);
endmodule

bind addr_stack_fault asf_checker #(
  .DAW(DAW), .PAW(PAW), .DMEM_LAST(DMEM_LAST), .XY_SPLIT(XY_SPLIT),
  .PMEM_END(PMEM_END), .VEC_LAST(VEC_LAST), .SP_FLOOR(SP_FLOOR)
) u_asf_checker (.*);

// File: tb/addr_stack_fault_test.sv
`timescale 1ns/1ps
module addr_stack_fault_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dv, dw, mac, my, pv, fv, sw;
  logic [15:0] da, sd, sl;
  logic [23:0] pa, fa;
  logic        at, st;
  logic [7:0]  cause;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  addr_stack_fault uut (
    .clk_i(clk), .rst_ni(rst_n),
    .dacc_valid_i(dv), .dacc_addr_i(da), .dacc_word_i(dw),
    .mac_i(mac), .mac_y_i(my),
    .pdat_valid_i(pv), .pdat_addr_i(pa),
    .fetch_valid_i(fv), .fetch_addr_i(fa),
    .sp_we_i(sw), .sp_wdata_i(sd), .splim_i(sl),
    .addr_trap_o(at), .stack_trap_o(st), .cause_o(cause)
  );

  task automatic compare(input string tag, input logic [7:0] exp);
    logic ea, es;
    ea = |exp[5:0];
    es = |exp[7:6];
    checks++;
    if (cause !== exp || at !== ea || st !== es) begin
      errors++;
      $display("FAIL %s: cause=%h addr_trap=%b stack_trap=%b, expected cause=%h addr_trap=%b stack_trap=%b",
               tag, cause, at, st, exp, ea, es);
    end
  endtask

  // monitor: one registered result per driven cycle
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) compare(tag_q.pop_front(), exp_q.pop_front());
  end

  task automatic quiet();
    dv = 0; dw = 0; mac = 0; my = 0; pv = 0; fv = 0; sw = 0;
    da = 16'h0000; pa = 24'h0; fa = 24'h0; sd = 16'h0000; sl = 16'h0FFE;
  endtask

  // driver: inputs set before the call; pushes expectation, advances one cycle
  task automatic step(input string tag, input logic [7:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    quiet();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    quiet();
    repeat (3) @(negedge clk);
    compare("R10 reset state", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    dv = 1; dw = 1; da = 16'h0101;          step("R1 word odd", 8'h01);
    dv = 1; dw = 0; da = 16'h0101;          step("R1 byte odd ok", 8'h00);
    dv = 1; dw = 1; da = 16'h0100;          step("R1 word even ok", 8'h00);
    // R2
    dv = 1; da = 16'h1000;                  step("R2 above data", 8'h02);
    dv = 1; da = 16'h0FFF;                  step("R2 last data ok", 8'h00);
    dv = 1; dw = 1; da = 16'h1001;          step("R9 misalign+unimpl", 8'h03);
    // R3
    pv = 1; pa = 24'h008000;                step("R3 pdat end", 8'h04);
    pv = 1; pa = 24'h007FFE;                step("R3 pdat ok", 8'h00);
    // R4
    fv = 1; fa = 24'h000000;                step("R4 vec base", 8'h08);
    fv = 1; fa = 24'h00007F;                step("R4 vec last", 8'h08);
    fv = 1; fa = 24'h000080;                step("R4 past vec ok", 8'h00);
    // R5
    fv = 1; fa = 24'h008000;                step("R5 fetch end", 8'h10);
    fv = 1; fa = 24'hFFFFFE;                step("R5 fetch high", 8'h10);
    fv = 1; fa = 24'h007FFE;                step("R5 fetch ok", 8'h00);
    // R6
    dv = 1; mac = 1; my = 0; da = 16'h0C00; step("R6 X in Y", 8'h20);
    dv = 1; mac = 1; my = 0; da = 16'h0BFE; step("R6 X ok", 8'h00);
    dv = 1; mac = 1; my = 1; da = 16'h0BFE; step("R6 Y in X", 8'h20);
    dv = 1; mac = 1; my = 1; da = 16'h0C00; step("R6 Y ok", 8'h00);
    dv = 1; mac = 0; da = 16'h0C00;         step("R6 no mac ok", 8'h00);
    dv = 1; mac = 1; my = 0; da = 16'h1000; step("R6 X beyond mem", 8'h02);
    // R7
    sw = 1; sl = 16'h08FF; sd = 16'h0900;   step("R7 over limit", 8'h40);
    sw = 1; sl = 16'h08FF; sd = 16'h08FF;   step("R7 at limit ok", 8'h00);
    // R8
    sw = 1; sd = 16'h07FE;                  step("R8 below floor", 8'h80);
    sw = 1; sd = 16'h0800;                  step("R8 floor ok", 8'h00);
    sw = 1; sl = 16'h0400; sd = 16'h0700;   step("R9 over and under", 8'hC0);
    // R9: both trap groups at once
    dv = 1; dw = 1; da = 16'h1001; fv = 1; fa = 24'h000010;
    sw = 1; sl = 16'h08FF; sd = 16'h0A00;   step("R9 both traps", 8'h4B);
    // R10: single-cycle result
    step("R10 clears next cycle", 8'h00);
    // R11: faulty values with strobes low
    da = 16'hFFFF; dw = 1; mac = 1; my = 1; pa = 24'hFFFFFF;
    fa = 24'h000000; sd = 16'h0001; sl = 16'h0000;
    step("R11 strobes low", 8'h00);

    // R10: asynchronous reset clears a pending fault
    sw = 1; sd = 16'h0002;                  step("R8 pre reset", 8'h80);
    sw = 1; sd = 16'h0002;
    @(posedge clk); #3;
    rst_n = 1'b0; #1;
    compare("R10 async reset", 8'h00);
    @(negedge clk);
    quiet();
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    compare("R10 after reset", 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule